// File: doc/BRIEF.md
# Sparse-Space Bus Address Decoder

This block takes one CPU physical access at a time and turns it into a request on a 32-bit PCI-style bus. It first works out which region the access falls in. The regions are interrupt-acknowledge/special cycle, I/O, configuration, sparse memory and dense memory. In the sparse regions the CPU address is the bus address shifted left by five bits, with the access size coded in the bits below that shift. The block undoes this encoding and produces the bus address, the transfer size, active-low byte enables and the data lane.

Sparse memory carries only 27 address bits from the CPU. Its upper five bus address bits come from an extension register that software loads through a small CSR write port. Dense memory passes its offset straight through and accepts only aligned longword and quadword accesses. Read data coming back from the bus is shifted down to bit 0 and masked to the access size before it goes to the CPU. An access that breaks a size or lane rule, or that falls outside every region, is refused: the block raises an error pulse and starts no bus cycle.

Top module: `sparse_bus_decoder`

## Requirements
- R1: The CPU address selects the region, and `bus_region` reports it with these codes: 1 for offsets 0x1A0000000–0x1BFFFFFFF (interrupt-acknowledge/special), 2 for 0x1C0000000–0x1DFFFFFFF (I/O), 3 for 0x1E0000000–0x1FFFFFFFF (configuration), 4 for 0x200000000–0x2FFFFFFFF (sparse memory) and 5 for 0x300000000–0x3FFFFFFFF (dense memory).
- R2: In a sparse region, the bus address is the offset within the region shifted right by 5. I/O and configuration bus addresses are 24 bits wide, so bits [31:24] are zero.
- R3: In sparse regions, CPU address bits [4:3] give the size: 00 is a byte (`bus_size`=0), 01 is a 16-bit word (`bus_size`=1) and 11 is a longword (`bus_size`=2). The code 10 is an error. CPU address bits [2:0] are ignored.
- R4: `bus_be_n` is active low and uses bit i for byte lane i, where the lane is bus address [1:0]. A byte at lane L clears only bit L. A word at lane L clears bits L and L+1. A longword or any dense access drives 4'b0000.
- R5: Sparse-memory and interrupt-acknowledge bus addresses take bits [31:27] from the extension register. I/O and configuration bus addresses never do.
- R6: In dense memory, the bus address equals CPU address [31:0], with no shift and no extension bits. `cpu_quad`=0 gives a longword (`bus_size`=2) and needs address [1:0]=0. `cpu_quad`=1 gives a quadword (`bus_size`=3) and needs address [2:0]=0.
- R7: The following raise `cpu_err` for exactly one cycle after acceptance and start no bus request: a word at lane 3, a longword at a nonzero lane, size code 10, a misaligned dense access, or an address outside every region. `cpu_ready` stays high.
- R8: `cpu_ready` is low from acceptance until the access completes. `bus_valid` rises the cycle after acceptance. Address, size, enables, region, write flag and data stay stable until `bus_ready`.
- R9: After a read has been handed to the bus, `cpu_rvalid` follows `bus_rvalid` in the same cycle. `cpu_rdata` is then `bus_rdata` shifted right by lane×8 and masked to 8, 16 or 32 bits according to the size.
- R10: The extension register resets to 0 and changes only on a CSR write. The bus address is captured at acceptance, so a CSR write during an in-flight request does not alter that request. It takes effect for the next request.
- R11: Write data and the write flag pass to the bus unchanged. A write completes, and `cpu_ready` returns high, in the cycle after `bus_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | Block can accept an access |
| cpu_addr | input | 34 | CPU physical address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_quad | input | 1 | Dense quadword access |
| cpu_wdata | input | 32 | Lane-placed write data |
| cpu_err | output | 1 | One-cycle rejection pulse |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 32 | Read data aligned to bit 0 |
| csr_we | input | 1 | Extension register write strobe |
| csr_wdata | input | 5 | Extension register value |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts request |
| bus_addr | output | 32 | Bus address |
| bus_region | output | 3 | Region code |
| bus_size | output | 2 | Transfer size code |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_write | output | 1 | Write request |
| bus_wdata | output | 32 | Write data |
| bus_rvalid | input | 1 | Read data returned |
| bus_rdata | input | 32 | Read data from bus |

## Verification
A wrong extension value shows up as bad bits [31:27] on the first sparse-memory or interrupt-acknowledge request after the fault. I/O and configuration requests do not reveal it. A wrong lane or size latched at acceptance shows up in the cycle after acceptance, as bad `bus_be_n` or `bus_size`. It shows up again, as misaligned `cpu_rdata`, in the same cycle that `bus_rvalid` returns. A handshake state that is stuck appears as `cpu_ready` staying low, or as `bus_valid` not dropping in the cycle after `bus_ready`. The bench compares these values against its own model after each acceptance, during stalls and on each data return.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
    localparam int CPU_AW       = 34;
    localparam int BUS_AW       = 32;
    localparam int BUS_DW       = 32;
    localparam int LANES        = BUS_DW / 8;
    localparam int LANE_W       = $clog2(LANES);
    localparam int SPARSE_SHIFT = 5;
    localparam int SMEM_BITS    = 27;
    localparam int IO_BITS      = 24;
    localparam int HAE_W        = BUS_AW - SMEM_BITS;
    localparam int SMALL_OFF_W  = IO_BITS + SPARSE_SHIFT;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_IACK = 3'd1,
        RG_IO   = 3'd2,
        RG_CONF = 3'd3,
        RG_SMEM = 3'd4,
        RG_DMEM = 3'd5
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_QUAD = 2'd3
    } xsize_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        region_e           region;
        xsize_e            size;
        logic [LANES-1:0]  be_n;
        logic              write;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    // Active-low lane enables for a transfer starting at a lane
    function automatic logic [LANES-1:0] lane_enables_n(xsize_e sz, logic [LANE_W-1:0] lane);
        logic [LANES-1:0] one;
        logic [LANES-1:0] m;
        one = LANES'(1);
        case (sz)
            SZ_BYTE: m = one << lane;
            SZ_WORD: m = (one | (one << 1)) << lane;
            default: m = '1;
        endcase
        return ~m;
    endfunction

    // Move returned lane data down to bit 0 and clip to the size
    function automatic logic [BUS_DW-1:0] align_down(logic [BUS_DW-1:0] d,
                                                     logic [LANE_W-1:0] lane,
                                                     xsize_e sz);
        logic [BUS_DW-1:0] sh;
        logic [BUS_DW-1:0] m;
        sh = d >> {lane, 3'b000};
        case (sz)
            SZ_BYTE: m = BUS_DW'(8'hFF);
            SZ_WORD: m = BUS_DW'(16'hFFFF);
            default: m = '1;
        endcase
        return sh & m;
    endfunction
endpackage

// File: rtl/sbd_hae_reg.sv
module sbd_hae_reg
    import sbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [HAE_W-1:0] wdata,
    output logic [HAE_W-1:0] hae
);
    always_ff @(posedge clk) begin
        if (rst)     hae <= '0;
        else if (we) hae <= wdata;
    end

    assert_hae_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(hae));
endmodule

// File: rtl/sbd_region_decode.sv
module sbd_region_decode
    import sbd_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_write,
    input  logic              cpu_quad,
    input  logic [BUS_DW-1:0] cpu_wdata,
    input  logic [HAE_W-1:0]  hae,
    output bus_req_t          req,
    output logic              bad
);
    localparam int WIN_W = BUS_AW - SMALL_OFF_W;
    localparam int GAP_W = SMEM_BITS - IO_BITS;

    logic [1:0]        code;
    logic [LANE_W-1:0] lane;
    logic [WIN_W-1:0]  win;
    logic [IO_BITS-1:0] small_ba;
    xsize_e            ssz;
    logic              sbad;

    always_comb begin
        code     = cpu_addr[4:3];
        lane     = cpu_addr[SPARSE_SHIFT +: LANE_W];
        win      = cpu_addr[BUS_AW-1:SMALL_OFF_W];
        small_ba = cpu_addr[SMALL_OFF_W-1:SPARSE_SHIFT];

        // sparse size code and lane legality
        sbad = 1'b0;
        case (code)
            2'b00:   ssz = SZ_BYTE;
            2'b01: begin
                ssz  = SZ_WORD;
                sbad = (lane == LANE_W'(LANES - 1));
            end
            2'b11: begin
                ssz  = SZ_LONG;
                sbad = (lane != '0);
            end
            default: begin
                ssz  = SZ_BYTE;
                sbad = 1'b1;
            end
        endcase

        req        = '0;
        req.write  = cpu_write;
        req.wdata  = cpu_wdata;
        req.size   = ssz;
        req.be_n   = lane_enables_n(ssz, lane);
        req.region = RG_NONE;
        bad        = 1'b1;

        case (cpu_addr[CPU_AW-1 -: 2])
            2'b11: begin
                req.region = RG_DMEM;
                req.addr   = cpu_addr[BUS_AW-1:0];
                req.be_n   = '0;
                req.size   = cpu_quad ? SZ_QUAD : SZ_LONG;
                bad        = cpu_quad ? (cpu_addr[2:0] != 3'b000)
                                      : (cpu_addr[1:0] != 2'b00);
            end
            2'b10: begin
                req.region = RG_SMEM;
                req.addr   = {hae, cpu_addr[BUS_AW-1:SPARSE_SHIFT]};
                bad        = sbad;
            end
            2'b01: begin
                case (win)
                    3'b101: begin
                        req.region = RG_IACK;
                        req.addr   = {hae, GAP_W'(0), small_ba};
                        bad        = sbad;
                    end
                    3'b110: begin
                        req.region = RG_IO;
                        req.addr   = BUS_AW'(small_ba);
                        bad        = sbad;
                    end
                    3'b111: begin
                        req.region = RG_CONF;
                        req.addr   = BUS_AW'(small_ba);
                        bad        = sbad;
                    end
                    default: bad = 1'b1;
                endcase
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/sbd_read_align.sv
module sbd_read_align
    import sbd_pkg::*;
(
    input  logic              valid,
    input  logic [BUS_DW-1:0] bus_rdata,
    input  logic [LANE_W-1:0] lane,
    input  xsize_e            size,
    output logic [BUS_DW-1:0] cpu_rdata
);
    always_comb begin
        cpu_rdata = align_down(bus_rdata, lane, size);
        if (valid && size == SZ_BYTE)
            assert_byte_top_clear_R9: assert (cpu_rdata[BUS_DW-1:8] == '0);
    end
endmodule

// File: rtl/sparse_bus_decoder.sv
module sparse_bus_decoder
    import sbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_write,
    input  logic              cpu_quad,
    input  logic [BUS_DW-1:0] cpu_wdata,
    output logic              cpu_err,
    output logic              cpu_rvalid,
    output logic [BUS_DW-1:0] cpu_rdata,
    input  logic              csr_we,
    input  logic [HAE_W-1:0]  csr_wdata,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [2:0]        bus_region,
    output logic [1:0]        bus_size,
    output logic [LANES-1:0]  bus_be_n,
    output logic              bus_write,
    output logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [BUS_DW-1:0] bus_rdata
);
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD} st_e;

    st_e              st;
    bus_req_t         dec_req;
    bus_req_t         req_q;
    logic             dec_bad;
    logic             accept;
    logic             err_q;
    logic [HAE_W-1:0] hae;

    sbd_hae_reg u_hae (
        .clk   (clk),
        .rst   (rst),
        .we    (csr_we),
        .wdata (csr_wdata),
        .hae   (hae)
    );

    sbd_region_decode u_dec (
        .cpu_addr  (cpu_addr),
        .cpu_write (cpu_write),
        .cpu_quad  (cpu_quad),
        .cpu_wdata (cpu_wdata),
        .hae       (hae),
        .req       (dec_req),
        .bad       (dec_bad)
    );

    assign cpu_ready = (st == ST_IDLE);
    assign accept    = cpu_valid && cpu_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            err_q <= 1'b0;
            req_q <= '0;
        end else begin
            err_q <= accept && dec_bad;
            case (st)
                ST_IDLE: if (accept && !dec_bad) begin
                    req_q <= dec_req;
                    st    <= ST_REQ;
                end
                ST_REQ: if (bus_ready)
                    st <= req_q.write ? ST_IDLE : ST_RD;
                ST_RD: if (bus_rvalid)
                    st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cpu_err    = err_q;
    assign bus_valid  = (st == ST_REQ);
    assign bus_addr   = req_q.addr;
    assign bus_region = req_q.region;
    assign bus_size   = req_q.size;
    assign bus_be_n   = req_q.be_n;
    assign bus_write  = req_q.write;
    assign bus_wdata  = req_q.wdata;
    assign cpu_rvalid = (st == ST_RD) && bus_rvalid;

    sbd_read_align u_ralign (
        .valid     (cpu_rvalid),
        .bus_rdata (bus_rdata),
        .lane      (req_q.addr[LANE_W-1:0]),
        .size      (req_q.size),
        .cpu_rdata (cpu_rdata)
    );

    assert_hold_req_R8: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
            && $stable(bus_be_n) && $stable(bus_size) && $stable(bus_wdata));
    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !cpu_ready);
    assert_err_noreq_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_err |-> !bus_valid && cpu_ready);
    assert_byte_onelane_R4: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_size == 2'd0 |-> $countones(bus_be_n) == LANES - 1);
    assert_rvalid_after_req_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> !bus_valid && !cpu_ready);
    assert_io_narrow_R2: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_region == 3'd2 |-> bus_addr[BUS_AW-1:IO_BITS] == '0);
endmodule

// File: tb/sparse_bus_decoder_bench.sv
module sparse_bus_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        cpu_ready;
    logic [33:0] cpu_addr = '0;
    logic        cpu_write = 1'b0;
    logic        cpu_quad = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_err;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        csr_we = 1'b0;
    logic [4:0]  csr_wdata = '0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_addr;
    logic [2:0]  bus_region;
    logic [1:0]  bus_size;
    logic [3:0]  bus_be_n;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    longint unsigned m_hae = 0;
    bit              e_err;
    longint unsigned e_addr;
    int              e_region;
    int              e_size;
    int              e_be;
    int              e_lane;

    always #(CLK_PERIOD/2) clk = ~clk;

    sparse_bus_decoder u_sparse_bus_decoder (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
        .cpu_write(cpu_write), .cpu_quad(cpu_quad), .cpu_wdata(cpu_wdata),
        .cpu_err(cpu_err), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .csr_we(csr_we), .csr_wdata(csr_wdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_region(bus_region), .bus_size(bus_size), .bus_be_n(bus_be_n),
        .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Behavioural reference: region, address, size, enables, legality
    task automatic model(input longint unsigned a, input bit quad);
        longint unsigned rel, ba;
        int code;
        e_err = 0; e_lane = 0; e_be = 0; e_size = 2; e_addr = 0;
        if      (a >= 64'h300000000) e_region = 5;
        else if (a >= 64'h200000000) e_region = 4;
        else if (a >= 64'h1E0000000) e_region = 3;
        else if (a >= 64'h1C0000000) e_region = 2;
        else if (a >= 64'h1A0000000) e_region = 1;
        else                         e_region = 0;
        if (e_region == 0) begin
            e_err = 1;
        end else if (e_region == 5) begin
            e_addr = a - 64'h300000000;
            e_size = quad ? 3 : 2;
            e_err  = quad ? ((a % 8) != 0) : ((a % 4) != 0);
        end else begin
            case (e_region)
                1: rel = a - 64'h1A0000000;
                2: rel = a - 64'h1C0000000;
                3: rel = a - 64'h1E0000000;
                default: rel = a - 64'h200000000;
            endcase
            ba     = rel / 32;
            code   = int'((rel / 8) % 4);
            e_lane = int'(ba % 4);
            if (e_region == 4 || e_region == 1) ba = ba + m_hae * 64'h8000000;
            e_addr = ba;
            case (code)
                0: begin e_size = 0; e_be = 15 - (1 << e_lane); end
                1: begin e_size = 1; e_be = 15 - (3 << e_lane); e_err = (e_lane == 3); end
                3: begin e_size = 2; e_be = 0; e_err = (e_lane != 0); end
                default: e_err = 1;
            endcase
        end
    endtask

    task automatic csr_write(input int v);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = 5'(v);
        @(negedge clk);
        csr_we = 1'b0;
        m_hae = longint'(v);
    endtask

    task automatic issue(input string req, input longint unsigned a, input bit wr,
                         input bit quad, input logic [31:0] wd);
        @(negedge clk);
        check({req, " ready before accept"}, cpu_ready, 1);
        cpu_valid = 1'b1; cpu_addr = a[33:0]; cpu_write = wr; cpu_quad = quad; cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 1'b0;
        model(a, quad);
        check({req, " err"}, cpu_err, e_err);
        check({req, " bus_valid"}, bus_valid, !e_err);
        if (e_err) begin
            check({req, " ready after reject R7"}, cpu_ready, 1);
            @(negedge clk);
            check({req, " err single pulse R7"}, cpu_err, 0);
        end else begin
            check({req, " region R1"}, bus_region, e_region);
            check({req, " addr R2/R5/R6"}, bus_addr, e_addr);
            check({req, " size R3"}, bus_size, e_size);
            check({req, " be_n R4"}, bus_be_n, e_be);
            check({req, " write R11"}, bus_write, wr);
            check({req, " wdata R11"}, bus_wdata, wd);
            check({req, " busy R8"}, cpu_ready, 0);
        end
    endtask

    task automatic complete(input string req, input bit wr, input logic [31:0] rd, input int stall);
        logic [31:0] hold_addr;
        longint unsigned exp_rd;
        hold_addr = bus_addr;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check({req, " stall valid R8"}, bus_valid, 1);
            check({req, " stall addr R8"}, bus_addr, hold_addr);
            check({req, " stall busy R8"}, cpu_ready, 0);
        end
        @(negedge clk);
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        check({req, " valid drops R8"}, bus_valid, 0);
        if (wr) begin
            check({req, " write done R11"}, cpu_ready, 1);
        end else begin
            check({req, " waiting read R9"}, cpu_ready, 0);
            check({req, " no early rvalid R9"}, cpu_rvalid, 0);
            bus_rvalid = 1'b1; bus_rdata = rd;
            #1;
            exp_rd = longint'(rd) >> (8 * e_lane);
            if (e_size == 0) exp_rd = exp_rd & 64'hFF;
            else if (e_size == 1) exp_rd = exp_rd & 64'hFFFF;
            else exp_rd = exp_rd & 64'hFFFFFFFF;
            check({req, " rvalid R9"}, cpu_rvalid, 1);
            check({req, " rdata R9"}, cpu_rdata, exp_rd);
            @(negedge clk);
            bus_rvalid = 1'b0;
            check({req, " read done R9"}, cpu_ready, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("reset ready R8", cpu_ready, 1);
        check("reset bus_valid R8", bus_valid, 0);
        check("reset err R7", cpu_err, 0);

        // I/O byte write, lane 1
        issue("R2 io byte wr", 64'h1C0000000 + (64'h3F9 << 5), 1, 0, 32'h00005A00);
        complete("R11 io byte wr", 1, 0, 0);
        // bits [2:0] ignored
        issue("R3 io byte low bits", 64'h1C0000000 + (64'h3F9 << 5) + 5, 1, 0, 32'h00005A00);
        complete("R3 io byte low bits", 1, 0, 0);
        // I/O word read lane 2 with stall
        issue("R4 io word rd", 64'h1C0000000 + (64'h62 << 5) + 8, 0, 0, 0);
        complete("R9 io word rd", 0, 32'hAABBCCDD, 3);
        // I/O long read
        issue("R3 io long rd", 64'h1C0000000 + (64'h100 << 5) + 24, 0, 0, 0);
        complete("R9 io long rd", 0, 32'h12345678, 0);
        // byte read lane 3
        issue("R9 io byte rd", 64'h1C0000000 + (64'h7 << 5), 0, 0, 0);
        complete("R9 io byte rd", 0, 32'hC3000000, 1);
        // sparse memory, extension register still zero after reset
        issue("R10 smem reset hae", 64'h200000000 + (64'h123456 << 5), 1, 0, 32'h00EE0000);
        complete("R10 smem reset hae", 1, 0, 0);
        csr_write(5'h15);
        issue("R5 smem word rd", 64'h200000000 + (64'h7ABCDE << 5) + 8, 0, 0, 0);
        complete("R5 smem word rd", 0, 32'h0000BEEF, 0);
        issue("R5 io ignores hae", 64'h1C0000000 + (64'hFFFFFF << 5), 0, 0, 0);
        complete("R5 io ignores hae", 0, 32'h11223344, 0);
        issue("R5 iack uses hae", 64'h1A0000000 + (64'h10 << 5) + 24, 0, 0, 0);
        complete("R5 iack uses hae", 0, 32'hCAFEF00D, 0);
        issue("R1 conf long", 64'h1E0000000 + (64'h800 << 5) + 24, 1, 0, 32'hDEADBEEF);
        complete("R1 conf long", 1, 0, 0);
        // dense
        issue("R6 dense long rd", 64'h300001004, 0, 0, 0);
        complete("R6 dense long rd", 0, 32'h87654321, 0);
        issue("R6 dense quad wr", 64'h3FFFFFFF8, 1, 1, 32'h0BADF00D);
        complete("R6 dense quad wr", 1, 0, 0);
        // rejections
        issue("R7 word lane3", 64'h1C0000000 + (64'h3 << 5) + 8, 0, 0, 0);
        issue("R7 long lane1", 64'h200000000 + (64'h1 << 5) + 24, 0, 0, 0);
        issue("R7 size code 10", 64'h1C0000000 + 16, 1, 0, 0);
        issue("R7 dense misaligned long", 64'h300000002, 0, 0, 0);
        issue("R7 dense misaligned quad", 64'h300000004, 1, 1, 0);
        issue("R7 unmapped", 64'h100000000, 0, 0, 0);
        // extension change while a request is in flight
        issue("R10 inflight", 64'h200000000 + (64'h40 << 5), 0, 0, 0);
        csr_write(5'h0A);
        m_hae = 64'h15;
        model(64'h200000000 + (64'h40 << 5), 0);
        check("R10 inflight addr unchanged", bus_addr, e_addr);
        m_hae = 64'h0A;
        complete("R10 inflight", 0, 32'h000000A5, 1);
        issue("R10 next uses new hae", 64'h200000000 + (64'h40 << 5), 0, 0, 0);
        complete("R10 next uses new hae", 0, 32'h0000005A, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule